// File: doc/BRIEF.md
# JTAG Chain Host Sequencer

This block is the host end of a JTAG daisy chain. It generates TCK from the system clock, drives TMS and TDI, and samples TDO. It runs one of three commands on the whole chain. The first puts every TAP into Test-Logic-Reset. The second loads an instruction into one chosen device and loads the bypass code into all the others. The third shifts a data value into the chosen device's data register. For each command the sequencer builds the whole chain-wide bit stream itself. It walks the TAP controllers to the right shift state and shifts the stream least-significant bit first. It then parks the chain in Run-Test/Idle and hands back the bits the target had captured.

Every device in the chain has the same instruction length, and the number of devices is a parameter. Devices are numbered from the TDO end, so device 0 is the one that drives the host's TDO pin. Its bits are sent first and returned first. The block keeps track of whether the chain is in Test-Logic-Reset or Run-Test/Idle, and picks the shorter TMS walk from there. The host must issue a reset command once before the first instruction or data command.

Top module: `jtag_chain_seq`

## Requirements
- R1: `cmd_op` 1 means instruction load and 2 means data shift. Codes 0 and 3 mean chain reset: TMS is held at 1 for exactly 7 TCK cycles, with no shifting, and the chain is then taken to be in Test-Logic-Reset.
- R2: TCK runs at half the clock rate and is low whenever the block is idle. TMS and TDI change only when TCK falls, never when it rises, and TDO is sampled on the clock edge that raises TCK.
- R3: The TMS walk before shifting is 0,1,1,0,0 from Test-Logic-Reset and 1,1,0,0 from Run-Test/Idle for an instruction load. For a data shift it is 0,1,0,0 from Test-Logic-Reset and 1,0,0 from Run-Test/Idle.
- R4: An instruction stream has N_DEV*IR_W bits. Device 0's code comes first, then device 1's, and so on. Each code is sent LSB first. The target gets `cmd_ir` and every other device gets the bypass code 3'b110 (defaults: 3 devices, 3-bit codes, so target 1 with code 3'b010 gives TDI 0,1,1,0,1,0,0,1,1).
- R5: A data stream has `cmd_dr_len` + N_DEV - 1 bits: one 0 filler bit for each device below the target, then the low `cmd_dr_len` bits of `cmd_dr` LSB first, then one 0 filler for each device above it (0xF5, length 8, target 1 gives TDI 0,1,0,1,0,1,1,1,1,0).
- R6: TMS is 1 together with the final shifted bit, and TMS is 1 then 0 on the next two TCK cycles. This leaves the chain in Run-Test/Idle with the register updated.
- R7: `rsp_data` holds the target's own captured bits. For an instruction load these are IR_W bits. For a data shift they are `cmd_dr_len` bits, LSB first. Bits from other devices are dropped and the upper bits are 0.
- R8: `cmd_ready` is high only while idle, and a command is taken when `cmd_valid` and `cmd_ready` are both high. `done` is a one-cycle pulse issued with `rsp_data` valid and TCK low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 2 | 0/3 reset, 1 instruction load, 2 data shift |
| cmd_target | input | TGT_W | Target device index, 0 nearest TDO |
| cmd_ir | input | IR_W | Instruction code for the target |
| cmd_dr | input | DR_MAX | Data value for the target |
| cmd_dr_len | input | LEN_W | Target data register length, 1..DR_MAX |
| done | output | 1 | Command finished pulse |
| rsp_data | output | RSP_W | Target's captured bits |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial data to the chain |
| tdo | input | 1 | Serial data from the chain |

## Verification
The bench runs against a behavioural chain of three TAP devices. In these devices code 010 selects an 8-bit register and code 011 selects a 4-bit register. Targets 0, 1 and 2 are each used, so any slip in where the target's bits sit in the outgoing stream or the returned stream shows up. The TMS walks are run from both Test-Logic-Reset and Run-Test/Idle to tell the two preamble choices apart. Back-to-back data writes show that the value returned is the one captured before the new one. A 4-bit shift with ones in the upper data bits, and a 1-bit shift through bypassed devices, show that only the requested length is sent and returned.

// File: rtl/jseq_pkg.sv
package jseq_pkg;
  typedef enum logic [1:0] {
    OP_RST  = 2'd0,
    OP_IR   = 2'd1,
    OP_DR   = 2'd2,
    OP_RST2 = 2'd3
  } op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SHIFT,
    ST_POST,
    ST_FIN
  } st_t;
endpackage

// File: rtl/jseq_tmsplan.sv
module jseq_tmsplan (
  input  logic       is_ir,
  input  logic       is_dr,
  input  logic       in_tlr,
  output logic [6:0] pat,
  output logic [2:0] plen
);
  // Patterns are sent from bit 0 upward.
  always_comb begin
    if (is_ir && in_tlr) begin
      pat = 7'b0000110; plen = 3'd5;
    end else if (is_ir) begin
      pat = 7'b0000011; plen = 3'd4;
    end else if (is_dr && in_tlr) begin
      pat = 7'b0000010; plen = 3'd4;
    end else if (is_dr) begin
      pat = 7'b0000001; plen = 3'd3;
    end else begin
      pat = 7'b1111111; plen = 3'd7;
    end
  end
endmodule

// File: rtl/jseq_stream.sv
module jseq_stream #(
  parameter int N_DEV  = 3,
  parameter int IR_W   = 3,
  parameter int DR_MAX = 8,
  parameter logic [IR_W-1:0] BYPASS_CODE = IR_W'(6),
  parameter int TGT_W  = 2,
  parameter int LEN_W  = 4,
  parameter int SH_W   = 10,
  parameter int CNT_W  = 4
) (
  input  logic              is_ir,
  input  logic [TGT_W-1:0]  tgt,
  input  logic [IR_W-1:0]   code,
  input  logic [DR_MAX-1:0] data,
  input  logic [LEN_W-1:0]  dlen,
  output logic [SH_W-1:0]   vec,
  output logic [CNT_W-1:0]  len
);
  localparam int IR_TOT = N_DEV * IR_W;

  logic [IR_TOT-1:0] ir_vec;
  logic [SH_W-1:0]   dmask;
  logic [SH_W-1:0]   dvec;

  for (genvar d = 0; d < N_DEV; d++) begin : g_slot
    assign ir_vec[d*IR_W +: IR_W] = (tgt == TGT_W'(d)) ? code : BYPASS_CODE;
  end

  assign dmask = (SH_W'(1) << dlen) - SH_W'(1);
  assign dvec  = (SH_W'(data) & dmask) << tgt;

  always_comb begin
    if (is_ir) begin
      vec = SH_W'(ir_vec);
      len = CNT_W'(IR_TOT);
    end else begin
      vec = dvec;
      len = CNT_W'(dlen) + CNT_W'(N_DEV - 1);
    end
  end
endmodule

// File: rtl/jseq_pick.sv
module jseq_pick #(
  parameter int IR_W  = 3,
  parameter int TGT_W = 2,
  parameter int LEN_W = 4,
  parameter int SH_W  = 10,
  parameter int RSP_W = 8
) (
  input  logic [SH_W-1:0]  cap,
  input  logic             is_ir,
  input  logic [TGT_W-1:0] tgt,
  input  logic [LEN_W-1:0] dlen,
  output logic [RSP_W-1:0] rsp
);
  logic [SH_W-1:0]  shifted;
  logic [RSP_W-1:0] mask;
  int               amt;
  int               nbits;

  always_comb begin
    amt     = is_ir ? int'(tgt) * IR_W : int'(tgt);
    nbits   = is_ir ? IR_W : int'(dlen);
    shifted = cap >> amt;
    mask    = RSP_W'(1);
    mask    = (mask << nbits) - RSP_W'(1);
    rsp     = RSP_W'(shifted) & mask;
  end
endmodule

// File: rtl/jtag_chain_seq.sv
module jtag_chain_seq
  import jseq_pkg::*;
#(
  parameter int N_DEV  = 3,
  parameter int IR_W   = 3,
  parameter int DR_MAX = 8,
  parameter logic [IR_W-1:0] BYPASS_CODE = IR_W'(6),
  localparam int TGT_W = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int LEN_W = $clog2(DR_MAX + 1),
  localparam int RSP_W = (IR_W > DR_MAX) ? IR_W : DR_MAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [TGT_W-1:0]  cmd_target,
  input  logic [IR_W-1:0]   cmd_ir,
  input  logic [DR_MAX-1:0] cmd_dr,
  input  logic [LEN_W-1:0]  cmd_dr_len,
  output logic              done,
  output logic [RSP_W-1:0]  rsp_data,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);
  localparam int IR_TOT = N_DEV * IR_W;
  localparam int DR_TOT = DR_MAX + N_DEV - 1;
  localparam int SH_W   = (IR_TOT > DR_TOT) ? IR_TOT : DR_TOT;
  localparam int CNT_RAW = $clog2(SH_W + 1);
  localparam int CNT_W  = (CNT_RAW > 3) ? CNT_RAW : 3;

  st_t               st_q;
  op_t               op_q;
  logic [TGT_W-1:0]  tgt_q;
  logic [IR_W-1:0]   ir_q;
  logic [DR_MAX-1:0] dr_q;
  logic [LEN_W-1:0]  len_q;
  logic              in_tlr_q;
  logic              ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SH_W-1:0]   cap_q;
  logic              tck_q, tms_q, tdi_q, done_q;
  logic [RSP_W-1:0]  rsp_q;

  logic              is_ir, is_dr;
  logic [6:0]        pat;
  logic [2:0]        plen;
  logic [SH_W-1:0]   svec;
  logic [CNT_W-1:0]  slen;
  logic [RSP_W-1:0]  pick;
  logic              step_tms, step_tdi, step_last;

  assign is_ir = (op_q == OP_IR);
  assign is_dr = (op_q == OP_DR);

  jseq_tmsplan u_plan (
    .is_ir (is_ir), .is_dr (is_dr), .in_tlr (in_tlr_q),
    .pat (pat), .plen (plen)
  );

  jseq_stream #(
    .N_DEV (N_DEV), .IR_W (IR_W), .DR_MAX (DR_MAX), .BYPASS_CODE (BYPASS_CODE),
    .TGT_W (TGT_W), .LEN_W (LEN_W), .SH_W (SH_W), .CNT_W (CNT_W)
  ) u_stream (
    .is_ir (is_ir), .tgt (tgt_q), .code (ir_q), .data (dr_q), .dlen (len_q),
    .vec (svec), .len (slen)
  );

  jseq_pick #(
    .IR_W (IR_W), .TGT_W (TGT_W), .LEN_W (LEN_W), .SH_W (SH_W), .RSP_W (RSP_W)
  ) u_pick (
    .cap (cap_q), .is_ir (is_ir), .tgt (tgt_q), .dlen (len_q), .rsp (pick)
  );

  // One TCK bit per step: what TMS/TDI carry and whether the phase ends.
  always_comb begin
    step_tms  = 1'b0;
    step_tdi  = 1'b0;
    step_last = 1'b0;
    unique case (st_q)
      ST_PRE: begin
        step_tms  = pat[cnt_q[2:0]];
        step_last = (cnt_q[2:0] == plen - 3'd1);
      end
      ST_SHIFT: begin
        step_tdi  = svec[cnt_q];
        step_last = (cnt_q == slen - CNT_W'(1));
        step_tms  = step_last;
      end
      ST_POST: begin
        step_tms  = (cnt_q == '0);
        step_last = (cnt_q == CNT_W'(1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_RST;
      tgt_q    <= '0;
      ir_q     <= '0;
      dr_q     <= '0;
      len_q    <= '0;
      in_tlr_q <= 1'b1;
      ph_q     <= 1'b0;
      cnt_q    <= '0;
      cap_q    <= '0;
      tck_q    <= 1'b0;
      tms_q    <= 1'b1;
      tdi_q    <= 1'b0;
      done_q   <= 1'b0;
      rsp_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q  <= op_t'(cmd_op);
            tgt_q <= cmd_target;
            ir_q  <= cmd_ir;
            dr_q  <= cmd_dr;
            len_q <= cmd_dr_len;
            cnt_q <= '0;
            ph_q  <= 1'b0;
            st_q  <= ST_PRE;
          end
        end
        ST_FIN: begin
          tck_q    <= 1'b0;
          done_q   <= 1'b1;
          rsp_q    <= pick;
          in_tlr_q <= !(is_ir || is_dr);
          st_q     <= ST_IDLE;
        end
        default: begin
          if (!ph_q) begin
            tck_q <= 1'b0;
            tms_q <= step_tms;
            tdi_q <= step_tdi;
            ph_q  <= 1'b1;
          end else begin
            tck_q <= 1'b1;
            ph_q  <= 1'b0;
            if (st_q == ST_SHIFT) cap_q[cnt_q] <= tdo;
            if (step_last) begin
              cnt_q <= '0;
              if (st_q == ST_PRE)
                st_q <= (is_ir || is_dr) ? ST_SHIFT : ST_FIN;
              else if (st_q == ST_SHIFT)
                st_q <= ST_POST;
              else
                st_q <= ST_FIN;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign done      = done_q;
  assign rsp_data  = rsp_q;
  assign tck       = tck_q;
  assign tms       = tms_q;
  assign tdi       = tdi_q;

  // R2: pins are steady across a rising TCK.
  p_pins_hold_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tck_q) |-> ($stable(tms_q) && $stable(tdi_q)));
  // R2: no TCK activity while idle.
  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !tck_q);
  // R8: completion lands in idle and lasts one cycle.
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> cmd_ready);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R6 / R1: final TMS level matches the parked state.
  p_end_tms_r6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (tms_q == !(is_ir || is_dr)));
endmodule

// File: tb/sim_jtag_chain_seq.sv
module sim_jtag_chain_seq;
  localparam int N = 3;
  localparam int IRW = 3;
  localparam int DRM = 8;
  localparam int TLR = 0, RTI = 1, SELDR = 2, CAPDR = 3, SHDR = 4, EX1DR = 5,
                 PSDR = 6, EX2DR = 7, UPDR = 8, SELIR = 9, CAPIR = 10,
                 SHIR = 11, EX1IR = 12, PSIR = 13, EX2IR = 14, UPIR = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [1:0] cmd_target = 2'd0;
  logic [2:0] cmd_ir = 3'd0;
  logic [7:0] cmd_dr = 8'd0;
  logic [3:0] cmd_dr_len = 4'd0;
  logic       done;
  logic [7:0] rsp_data;
  logic       tck, tms, tdi;
  logic       tdo_m = 1'b0;

  int errors = 0;
  int checks = 0;
  bit busy = 0;

  always #5 clk = ~clk;

  jtag_chain_seq #(.N_DEV(N), .IR_W(IRW), .DR_MAX(DRM)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_target(cmd_target), .cmd_ir(cmd_ir), .cmd_dr(cmd_dr),
    .cmd_dr_len(cmd_dr_len), .done(done), .rsp_data(rsp_data),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo_m)
  );

  // Behavioural chain: device 0 drives TDO, device N-1 receives TDI.
  int         tap = TLR;
  logic [2:0] m_ir[N];
  logic [2:0] m_irsr[N];
  logic [7:0] m_dsr[N];
  logic [7:0] m_reg8[N];
  logic [3:0] m_reg4[N];
  bit         q_tms[$];
  bit         q_tdi[$];

  function automatic int dlen_of(logic [2:0] c);
    if (c == 3'b010) return 8;
    if (c == 3'b011) return 4;
    return 1;
  endfunction

  function automatic int nxt(int s, bit m);
    case (s)
      TLR:   return m ? TLR : RTI;
      RTI:   return m ? SELDR : RTI;
      SELDR: return m ? SELIR : CAPDR;
      CAPDR: return m ? EX1DR : SHDR;
      SHDR:  return m ? EX1DR : SHDR;
      EX1DR: return m ? UPDR : PSDR;
      PSDR:  return m ? EX2DR : PSDR;
      EX2DR: return m ? UPDR : SHDR;
      UPDR:  return m ? SELDR : RTI;
      SELIR: return m ? TLR : CAPIR;
      CAPIR: return m ? EX1IR : SHIR;
      SHIR:  return m ? EX1IR : SHIR;
      EX1IR: return m ? UPIR : PSIR;
      PSIR:  return m ? EX2IR : PSIR;
      EX2IR: return m ? UPIR : SHIR;
      default: return m ? SELDR : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    bit outs[N];
    q_tms.push_back(tms);
    q_tdi.push_back(tdi);
    for (int k = 0; k < N; k++) begin
      outs[k] = (tap == SHIR) ? m_irsr[k][0] : m_dsr[k][0];
    end
    for (int k = 0; k < N; k++) begin
      bit in_b;
      int L;
      in_b = (k == N - 1) ? tdi : outs[k + 1];
      case (tap)
        TLR:   m_ir[k] = 3'b110;
        CAPIR: m_irsr[k] = 3'b001;
        SHIR:  m_irsr[k] = {in_b, m_irsr[k][2:1]};
        UPIR:  m_ir[k] = m_irsr[k];
        CAPDR: begin
          if (m_ir[k] == 3'b010) m_dsr[k] = m_reg8[k];
          else if (m_ir[k] == 3'b011) m_dsr[k] = {4'd0, m_reg4[k]};
          else m_dsr[k] = 8'd0;
        end
        SHDR: begin
          L = dlen_of(m_ir[k]);
          m_dsr[k] = m_dsr[k] >> 1;
          m_dsr[k][L - 1] = in_b;
        end
        UPDR: begin
          if (m_ir[k] == 3'b010) m_reg8[k] = m_dsr[k];
          else if (m_ir[k] == 3'b011) m_reg4[k] = m_dsr[k][3:0];
        end
        default: ;
      endcase
    end
    tap = nxt(tap, tms);
    if (tap == SHDR) tdo_m = m_dsr[0][0];
    else if (tap == SHIR) tdo_m = m_irsr[0][0];
    else tdo_m = 1'b0;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Per-clock comparison of pin behaviour.
  bit p_tck = 0, p_tms = 1, p_tdi = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!p_tck && tck)
        check(tms == p_tms && tdi == p_tdi, "R2", "pins moved at TCK rise",
              {tms, tdi}, {p_tms, p_tdi});
      if (cmd_ready && tck) check(0, "R2", "TCK high while idle", 1, 0);
      if (busy && cmd_ready) check(0, "R8", "ready while busy", 1, 0);
    end
    p_tck = tck; p_tms = tms; p_tdi = tdi;
  end

  task automatic cmp_q(string req, string what, bit a[$], bit e[$]);
    bit ok;
    int bad;
    ok = (a.size() == e.size());
    bad = -1;
    for (int i = 0; i < e.size() && ok; i++) begin
      if (a[i] != e[i]) begin ok = 0; bad = i; end
    end
    check(ok, req, $sformatf("%s (size/first bad index %0d)", what, bad),
          a.size(), e.size());
  endtask

  task automatic run(int op, int t, logic [2:0] ir, logic [7:0] dr, int len,
                     int exp_rsp, string req);
    bit etms[$];
    bit etdi[$];
    bit was_tlr;
    int n;
    was_tlr = (tap == TLR);
    q_tms.delete();
    q_tdi.delete();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_target = t[1:0];
    cmd_ir = ir; cmd_dr = dr; cmd_dr_len = len[3:0];
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    busy = 1;
    while (!done) @(negedge clk);
    busy = 0;
    if (op == 1 || op == 2) begin
      if (op == 1) begin
        if (was_tlr) etms = '{0, 1, 1, 0, 0}; else etms = '{1, 1, 0, 0};
      end else begin
        if (was_tlr) etms = '{0, 1, 0, 0}; else etms = '{1, 0, 0};
      end
      for (int i = 0; i < etms.size(); i++) etdi.push_back(0);
      if (op == 1) begin
        for (int d = 0; d < N; d++)
          for (int b = 0; b < IRW; b++)
            etdi.push_back((d == t) ? ir[b] : ((3'b110 >> b) & 1));
      end else begin
        for (int d = 0; d < t; d++) etdi.push_back(0);
        for (int b = 0; b < len; b++) etdi.push_back(dr[b]);
        for (int d = t + 1; d < N; d++) etdi.push_back(0);
      end
      n = etdi.size() - etms.size();
      for (int i = 0; i < n; i++) etms.push_back(i == n - 1);
      etms.push_back(1); etms.push_back(0);
      etdi.push_back(0); etdi.push_back(0);
      cmp_q("R3/R6", "TMS sequence", q_tms, etms);
      cmp_q(op == 1 ? "R4" : "R5", "TDI sequence", q_tdi, etdi);
      check(rsp_data == exp_rsp[7:0], "R7", "captured bits", rsp_data, exp_rsp);
      check(tap == RTI, "R6", "chain parked state", tap, RTI);
    end else begin
      for (int i = 0; i < 7; i++) begin etms.push_back(1); etdi.push_back(0); end
      cmp_q("R1", "reset TMS", q_tms, etms);
      check(tap == TLR, "R1", "chain state after reset", tap, TLR);
    end
    @(negedge clk);
    check(!done, "R8", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", "run did not finish", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit seg[$];
    for (int k = 0; k < N; k++) begin
      m_ir[k] = 3'b110; m_irsr[k] = 3'd0; m_dsr[k] = 8'd0;
    end
    m_reg8[0] = 8'h3C; m_reg8[1] = 8'hC3; m_reg8[2] = 8'h81;
    m_reg4[0] = 4'h5;  m_reg4[1] = 4'h9;  m_reg4[2] = 4'h6;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_ready == 1 && done == 0, "R8", "reset ready/done", {cmd_ready, done}, 2);
    check(tck == 0 && tms == 1 && tdi == 0, "R2", "reset pins", {tck, tms, tdi}, 3'b010);

    run(0, 0, 3'd0, 8'h00, 1, 0, "R1");
    run(1, 1, 3'b010, 8'h00, 1, 1, "R4");
    seg = q_tdi[5:13];
    cmp_q("R4", "IR example stream", seg, '{0, 1, 1, 0, 1, 0, 0, 1, 1});
    check(m_ir[0] == 3'b110 && m_ir[1] == 3'b010 && m_ir[2] == 3'b110, "R4",
          "loaded codes", {m_ir[2], m_ir[1], m_ir[0]}, 9'b110010110);

    run(2, 1, 3'd0, 8'hF5, 8, 8'hC3, "R5");
    seg = q_tdi[3:12];
    cmp_q("R5", "DR example stream", seg, '{0, 1, 0, 1, 0, 1, 1, 1, 1, 0});
    check(m_reg8[1] == 8'hF5, "R6", "register updated", m_reg8[1], 8'hF5);
    run(2, 1, 3'd0, 8'h5A, 8, 8'hF5, "R7");

    run(1, 2, 3'b011, 8'h00, 1, 1, "R3");
    run(2, 2, 3'd0, 8'hFA, 4, 4'h6, "R5");
    check(m_reg4[2] == 4'hA, "R5", "short register updated", m_reg4[2], 4'hA);

    run(1, 0, 3'b010, 8'h00, 1, 1, "R4");
    run(2, 0, 3'd0, 8'h33, 8, 8'h3C, "R7");
    check(m_reg8[0] == 8'h33, "R5", "device 0 register", m_reg8[0], 8'h33);

    run(3, 0, 3'd0, 8'h00, 1, 0, "R1");
    run(2, 1, 3'd0, 8'h01, 1, 0, "R3");
    run(0, 0, 3'd0, 8'h00, 1, 0, "R1");

    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule